// File: doc/BRIEF.md
# Half-Duplex Video Expansion Port

This block is a 4:2:2 component video port that carries traffic in one direction at a time. While it is pointed outward it takes decoder samples (10-bit Cb, Y and Cr) and places them byte-serially on an 8-bit bus in the order Cb, Y, Cr, Y. The samples go out either at full precision, with the upper eight bits on the bus and the two lowest bits on a pair of sideband lines, or reduced to eight bits with LFSR dither. While it is pointed inward it accepts byte-serial 8-bit video, or a split 16-bit form with luma on the main bus and chroma on a second bus, and hands each sample to the internal image path with a tag naming its component.

A direction request is sampled only on the cycle that marks the start of a field. The new direction takes hold at that one clock edge for the output drivers, the bus enable and the input capture, so no field is ever carried partly one way and partly the other. In output mode a single configuration bit turns on the insertion of start-of-active and end-of-active timing codes. The external timing source pulses a start strobe together with the F, V and H flags, and the port replaces the next four bus bytes with the code. While insertion is enabled, the values 00 and FF are kept out of the sample stream.

Top module: `vxport`

## Requirements
- R1: While reset is low and on the first cycle after it, xd_oe, xd_o, xlsb_o and every img_* output are 0, and the direction is input.
- R2: dir_req (1 = output, 0 = input) is taken only in a cycle with fld_start high. xd_oe, the bus outputs and the input capture all follow the new direction from the clock edge that ends that cycle. A request made mid-field has no effect until the next fld_start.
- R3: In output direction no img_* valid is ever raised. In input direction xd_oe, xd_o and xlsb_o stay 0.
- R4: The output phase restarts at Cb on the first cycle of dec_act high (previous cycle low) and then advances every cycle, giving 0 Cb, 1 Y, 2 Cr, 3 Y. Each output appears one clock after its inputs.
- R5: With out_10b=1 and no code slot, xd_o is sample bits [9:2] and xlsb_o is bits [1:0].
- R6: With out_10b=0 and no code slot, xd_o = min(255, (sample + d) >> 2), where d is the LFSR's two low bits, and xlsb_o = 0.
- R7: The 16-bit LFSR resets to ACE1 hex. In each output-direction cycle with dec_act high it shifts left and takes in bit15^bit13^bit12^bit10. Dither uses the value from before the shift.
- R8: With code_en=1, a code_start in cycle t makes the four bus bytes that follow t into FF, 00, 00, XY, and xlsb_o=0 during them. XY bits 7..0 are 1, F, V, H, V^H, F^H, F^V, F^V^H, with F, V and H taken at t. A new code_start restarts the sequence.
- R9: With code_en=0, code_start has no effect and samples pass as in R5 and R6.
- R10: With code_en=1, non-code output is clamped. In 8-bit mode the dithered byte is held to 01..FE. In 10-bit mode the sample is held to 004..3FB before it is split.
- R11: In byte input mode (wide_in=0) the input phase restarts at 0 on the first cycle of in_act. Phases 0 and 2 give img_c_vld with img_c=xin_a and img_c_cr 0 or 1 respectively. Phases 1 and 3 give img_y_vld with img_y=xin_a. Outputs appear one clock later, and a field that is not valid reads 0.
- R12: In 16-bit input mode every in_act cycle raises both valids, with img_y=xin_a and img_c=xin_b. img_c_cr alternates 0, 1 starting at 0 on the first in_act cycle.
- R13: A cycle with in_act low produces no img_* valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_req | input | 1 | Requested direction, 1 = output |
| fld_start | input | 1 | Field start strobe |
| code_en | input | 1 | Enable timing code insertion and clamping |
| out_10b | input | 1 | 1 = 10-bit output, 0 = dithered 8-bit |
| wide_in | input | 1 | 1 = split 16-bit input |
| dec_act | input | 1 | Decoder active-video flag |
| dec_cb | input | 10 | Decoder Cb sample |
| dec_y | input | 10 | Decoder Y sample |
| dec_cr | input | 10 | Decoder Cr sample |
| code_start | input | 1 | Start of a four-byte timing code |
| code_f | input | 1 | Field flag for the code |
| code_v | input | 1 | Vertical blanking flag for the code |
| code_h | input | 1 | 0 = start of active, 1 = end of active |
| xd_o | output | 8 | Output bus data |
| xd_oe | output | 1 | Output bus enable |
| xlsb_o | output | 2 | Sideband low bits in 10-bit output |
| xin_a | input | 8 | Main input bus (byte-serial or luma) |
| xin_b | input | 8 | Second input bus (chroma in 16-bit mode) |
| in_act | input | 1 | Input data valid |
| img_y_vld | output | 1 | Luma sample valid to image path |
| img_y | output | 8 | Luma sample |
| img_c_vld | output | 1 | Chroma sample valid to image path |
| img_c | output | 8 | Chroma sample |
| img_c_cr | output | 1 | Chroma tag, 1 = Cr, 0 = Cb |

## Verification
Two events can meet in one cycle: a field-boundary direction change and a timing code that is in progress or just starting. The bench raises fld_start with a switch to input while a code is at its third byte, and later raises fld_start with a switch to output in the very cycle of code_start. It judges both against its cycle model. In the first case the bus must drop to 0 with the enable on the same edge and input capture must begin. In the second the full FF, 00, 00, XY sequence must appear with the enable rising on the FF byte.

// File: rtl/vxp_pkg.sv
package vxp_pkg;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_YA = 2'd1,
    PH_CR = 2'd2,
    PH_YB = 2'd3
  } comp_ph_e;

  function automatic logic [15:0] lfsr_next(input logic [15:0] cur);
    return {cur[14:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
  endfunction

  // fourth code byte: marker bit, flags, then four protection bits
  function automatic logic [7:0] xy_byte(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vxp_dir_ctl.sv
module vxp_dir_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fld_start,
  input  logic dir_req,
  output logic dir_nxt,
  output logic dir_q
);

  assign dir_nxt = fld_start ? dir_req : dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_nxt;
  end

  // R2: direction moves only after a field start cycle
  assert_dir_at_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_q) |-> $past(fld_start));

endmodule

// File: rtl/vxp_code_gen.sv
module vxp_code_gen
  import vxp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       f_in,
  input  logic       v_in,
  input  logic       h_in,
  output logic       slot,
  output logic       mid,
  output logic [7:0] code_byte
);

  logic [1:0] cph_q;
  logic [1:0] idx;
  logic       f_q, v_q, h_q;

  assign slot = start | (cph_q != 2'd0);
  assign idx  = start ? 2'd0 : cph_q;
  assign mid  = slot & ((idx == 2'd1) | (idx == 2'd2));

  always_comb begin
    case (idx)
      2'd0:    code_byte = 8'hFF;
      2'd3:    code_byte = xy_byte(f_q, v_q, h_q);
      default: code_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cph_q <= 2'd0;
      f_q   <= 1'b0;
      v_q   <= 1'b0;
      h_q   <= 1'b0;
    end else if (start) begin
      cph_q <= 2'd1;
      f_q   <= f_in;
      v_q   <= v_in;
      h_q   <= h_in;
    end else if (cph_q != 2'd0) begin
      cph_q <= cph_q + 2'd1;
    end
  end

endmodule

// File: rtl/vxp_out_path.sv
module vxp_out_path
  import vxp_pkg::*;
#(
  parameter int          SMP_W = 10,
  parameter int          BUS_W = 8,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_nxt,
  input  logic              out_10b,
  input  logic              code_en,
  input  logic              dec_act,
  input  logic [SMP_W-1:0]  dec_cb,
  input  logic [SMP_W-1:0]  dec_y,
  input  logic [SMP_W-1:0]  dec_cr,
  input  logic              code_slot,
  input  logic              code_mid,
  input  logic [BUS_W-1:0]  code_byte,
  output logic [BUS_W-1:0]  xd_o,
  output logic [SMP_W-BUS_W-1:0] xlsb_o
);

  localparam int LSB_W = SMP_W - BUS_W;
  localparam logic [SMP_W-1:0] SMP_LO = SMP_W'(1) << LSB_W;
  localparam logic [SMP_W-1:0] SMP_HI = ~SMP_LO;
  localparam logic [BUS_W-1:0] BUS_LO = BUS_W'(1);
  localparam logic [BUS_W-1:0] BUS_HI = ~BUS_LO;

  function automatic logic [BUS_W-1:0] dither_reduce(input logic [SMP_W-1:0] s,
                                                     input logic [LSB_W-1:0] d);
    logic [SMP_W:0] sum;
    sum = {1'b0, s} + {{(SMP_W + 1 - LSB_W){1'b0}}, d};
    if (sum[SMP_W]) return '1;
    return sum[SMP_W-1:LSB_W];
  endfunction

  function automatic logic [SMP_W-1:0] clamp_smp(input logic [SMP_W-1:0] s);
    if (s < SMP_LO) return SMP_LO;
    if (s > SMP_HI) return SMP_HI;
    return s;
  endfunction

  function automatic logic [BUS_W-1:0] clamp_bus(input logic [BUS_W-1:0] b);
    if (b < BUS_LO) return BUS_LO;
    if (b > BUS_HI) return BUS_HI;
    return b;
  endfunction

  comp_ph_e         ph_q, cur_ph;
  logic             act_q;
  logic [15:0]      lfsr_q;
  logic [SMP_W-1:0] smp, smp_c;
  logic [BUS_W-1:0] bus_n;
  logic [LSB_W-1:0] lsb_n;
  logic             adv;

  assign adv = dir_nxt & dec_act;

  always_comb begin
    cur_ph = (dec_act && !act_q) ? PH_CB : ph_q;
    case (cur_ph)
      PH_CB:   smp = dec_cb;
      PH_CR:   smp = dec_cr;
      default: smp = dec_y;
    endcase
    smp_c = code_en ? clamp_smp(smp) : smp;
    bus_n = '0;
    lsb_n = '0;
    if (code_slot) begin
      bus_n = code_byte;
    end else if (out_10b) begin
      bus_n = smp_c[SMP_W-1:LSB_W];
      lsb_n = smp_c[LSB_W-1:0];
    end else begin
      bus_n = dither_reduce(smp, lfsr_q[LSB_W-1:0]);
      if (code_en) bus_n = clamp_bus(bus_n);
    end
    if (!dir_nxt) begin
      bus_n = '0;
      lsb_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_CB;
      act_q  <= 1'b0;
      lfsr_q <= SEED;
      xd_o   <= '0;
      xlsb_o <= '0;
    end else begin
      ph_q   <= comp_ph_e'(2'(cur_ph) + 2'd1);
      act_q  <= dec_act;
      if (adv) lfsr_q <= lfsr_next(lfsr_q);
      xd_o   <= bus_n;
      xlsb_o <= lsb_n;
    end
  end

  assert_lsb_zero_8b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_10b) |=> (xlsb_o == '0));

  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000);

  assert_code_mid_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_nxt && code_mid) |=> (xd_o == '0));

  assert_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_nxt && code_en && !code_slot) |=> (xd_o != '0 && xd_o != '1));

endmodule

// File: rtl/vxp_in_path.sv
module vxp_in_path #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_nxt,
  input  logic             wide_in,
  input  logic             in_act,
  input  logic [BUS_W-1:0] xin_a,
  input  logic [BUS_W-1:0] xin_b,
  output logic             img_y_vld,
  output logic [BUS_W-1:0] img_y,
  output logic             img_c_vld,
  output logic [BUS_W-1:0] img_c,
  output logic             img_c_cr
);

  logic [1:0]       iph_q, cur_ph;
  logic             inq;
  logic             take;
  logic             yv_n, cv_n, cr_n;
  logic [BUS_W-1:0] y_n, c_n;

  assign take = ~dir_nxt & in_act;

  always_comb begin
    cur_ph = (in_act && !inq) ? 2'd0 : iph_q;
    yv_n = 1'b0; cv_n = 1'b0; cr_n = 1'b0;
    y_n  = '0;   c_n  = '0;
    if (take) begin
      if (wide_in) begin
        yv_n = 1'b1; y_n = xin_a;
        cv_n = 1'b1; c_n = xin_b;
        cr_n = cur_ph[0];
      end else if (cur_ph[0]) begin
        yv_n = 1'b1; y_n = xin_a;
      end else begin
        cv_n = 1'b1; c_n = xin_a;
        cr_n = cur_ph[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iph_q     <= 2'd0;
      inq       <= 1'b0;
      img_y_vld <= 1'b0;
      img_y     <= '0;
      img_c_vld <= 1'b0;
      img_c     <= '0;
      img_c_cr  <= 1'b0;
    end else begin
      iph_q     <= cur_ph + 2'd1;
      inq       <= in_act;
      img_y_vld <= yv_n;
      img_y     <= y_n;
      img_c_vld <= cv_n;
      img_c     <= c_n;
      img_c_cr  <= cr_n;
    end
  end

  assert_byte_in_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_nxt && in_act && !wide_in) |=> $onehot({img_y_vld, img_c_vld}));

  assert_wide_in_both_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_nxt && in_act && wide_in) |=> (img_y_vld && img_c_vld));

  assert_idle_in_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_act) |=> (!img_y_vld && !img_c_vld));

endmodule

// File: rtl/vxport.sv
module vxport
  import vxp_pkg::*;
#(
  parameter int          SMP_W = 10,
  parameter int          BUS_W = 8,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dir_req,
  input  logic                   fld_start,
  input  logic                   code_en,
  input  logic                   out_10b,
  input  logic                   wide_in,
  input  logic                   dec_act,
  input  logic [SMP_W-1:0]       dec_cb,
  input  logic [SMP_W-1:0]       dec_y,
  input  logic [SMP_W-1:0]       dec_cr,
  input  logic                   code_start,
  input  logic                   code_f,
  input  logic                   code_v,
  input  logic                   code_h,
  output logic [BUS_W-1:0]       xd_o,
  output logic                   xd_oe,
  output logic [SMP_W-BUS_W-1:0] xlsb_o,
  input  logic [BUS_W-1:0]       xin_a,
  input  logic [BUS_W-1:0]       xin_b,
  input  logic                   in_act,
  output logic                   img_y_vld,
  output logic [BUS_W-1:0]       img_y,
  output logic                   img_c_vld,
  output logic [BUS_W-1:0]       img_c,
  output logic                   img_c_cr
);

  logic       dir_nxt;
  logic       dir_q;
  logic       code_slot;
  logic       code_mid;
  logic [7:0] code_byte;

  vxp_dir_ctl u_dir (
    .clk       (clk),
    .rst_n     (rst_n),
    .fld_start (fld_start),
    .dir_req   (dir_req),
    .dir_nxt   (dir_nxt),
    .dir_q     (dir_q)
  );

  assign xd_oe = dir_q;

  vxp_code_gen u_code (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (code_en & code_start),
    .f_in      (code_f),
    .v_in      (code_v),
    .h_in      (code_h),
    .slot      (code_slot),
    .mid       (code_mid),
    .code_byte (code_byte)
  );

  vxp_out_path #(.SMP_W(SMP_W), .BUS_W(BUS_W), .SEED(SEED)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_nxt   (dir_nxt),
    .out_10b   (out_10b),
    .code_en   (code_en),
    .dec_act   (dec_act),
    .dec_cb    (dec_cb),
    .dec_y     (dec_y),
    .dec_cr    (dec_cr),
    .code_slot (code_slot),
    .code_mid  (code_mid),
    .code_byte (code_byte),
    .xd_o      (xd_o),
    .xlsb_o    (xlsb_o)
  );

  vxp_in_path #(.BUS_W(BUS_W)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_nxt   (dir_nxt),
    .wide_in   (wide_in),
    .in_act    (in_act),
    .xin_a     (xin_a),
    .xin_b     (xin_b),
    .img_y_vld (img_y_vld),
    .img_y     (img_y),
    .img_c_vld (img_c_vld),
    .img_c     (img_c),
    .img_c_cr  (img_c_cr)
  );

  // R3: capture and drive never overlap
  assert_half_duplex_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (img_y_vld || img_c_vld) |-> !xd_oe);

  assert_quiet_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xd_oe |-> (xd_o == '0 && xlsb_o == '0));

endmodule

// File: tb/tb_vxport.sv
module tb_vxport;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_req = 0, fld_start = 0, code_en = 0, out_10b = 0, wide_in = 0;
  logic       dec_act = 0, code_start = 0, code_f = 0, code_v = 0, code_h = 0;
  logic [9:0] dec_cb = 0, dec_y = 0, dec_cr = 0;
  logic [7:0] xin_a = 0, xin_b = 0;
  logic       in_act = 0;
  logic [7:0] xd_o, img_y, img_c;
  logic       xd_oe, img_y_vld, img_c_vld, img_c_cr;
  logic [1:0] xlsb_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vxport dut (
    .clk(clk), .rst_n(rst_n), .dir_req(dir_req), .fld_start(fld_start),
    .code_en(code_en), .out_10b(out_10b), .wide_in(wide_in), .dec_act(dec_act),
    .dec_cb(dec_cb), .dec_y(dec_y), .dec_cr(dec_cr), .code_start(code_start),
    .code_f(code_f), .code_v(code_v), .code_h(code_h), .xd_o(xd_o), .xd_oe(xd_oe),
    .xlsb_o(xlsb_o), .xin_a(xin_a), .xin_b(xin_b), .in_act(in_act),
    .img_y_vld(img_y_vld), .img_y(img_y), .img_c_vld(img_c_vld), .img_c(img_c),
    .img_c_cr(img_c_cr)
  );

  // model state
  bit        m_dir = 0, m_actq = 0, m_inq = 0, m_f = 0, m_v = 0, m_h = 0;
  int        m_ph = 0, m_iph = 0, m_cph = 0;
  bit [15:0] m_lfsr = 16'hACE1;

  function automatic int b_xy(bit f, bit v, bit h);
    return 128 + 64*f + 32*v + 16*h + 8*(v^h) + 4*(f^h) + 2*(f^v) + (f^v^h);
  endfunction

  function automatic logic [29:0] dut_vec();
    return {xd_oe, xd_o, xlsb_o, img_y_vld, img_y, img_c_vld, img_c, img_c_cr};
  endfunction

  task automatic chk(string tag, logic [29:0] act, logic [29:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit dn, st, slot, yv, cv, ccr;
    int cp, ip, s, idx, bus, lsb, y, c, t;
    dn = fld_start ? dir_req : m_dir;
    cp = (dec_act && !m_actq) ? 0 : m_ph;
    s  = (cp == 0) ? int'(dec_cb) : (cp == 2) ? int'(dec_cr) : int'(dec_y);
    st = code_en && code_start;
    slot = st || (m_cph != 0);
    idx = st ? 0 : m_cph;
    bus = 0; lsb = 0;
    if (slot) bus = (idx == 0) ? 255 : (idx == 3) ? b_xy(m_f, m_v, m_h) : 0;
    else if (out_10b) begin
      t = s;
      if (code_en) begin if (t < 4) t = 4; if (t > 1019) t = 1019; end
      bus = t / 4; lsb = t % 4;
    end else begin
      t = (s + int'(m_lfsr % 4)) / 4;
      if (t > 255) t = 255;
      if (code_en) begin if (t < 1) t = 1; if (t > 254) t = 254; end
      bus = t;
    end
    if (!dn) begin bus = 0; lsb = 0; end
    ip = (in_act && !m_inq) ? 0 : m_iph;
    yv = 0; cv = 0; ccr = 0; y = 0; c = 0;
    if (!dn && in_act) begin
      if (wide_in) begin yv = 1; cv = 1; y = xin_a; c = xin_b; ccr = ip % 2; end
      else if (ip % 2 == 1) begin yv = 1; y = xin_a; end
      else begin cv = 1; c = xin_a; ccr = (ip == 2); end
    end
    // advance model
    if (dn && dec_act) m_lfsr = {m_lfsr[14:0], m_lfsr[15]^m_lfsr[13]^m_lfsr[12]^m_lfsr[10]};
    m_dir = dn; m_ph = (cp + 1) % 4; m_actq = dec_act;
    if (st) begin m_cph = 1; m_f = code_f; m_v = code_v; m_h = code_h; end
    else if (m_cph != 0) m_cph = (m_cph + 1) % 4;
    m_iph = (ip + 1) % 4; m_inq = in_act;
    @(posedge clk);
    @(negedge clk);
    fld_start = 0; code_start = 0;
    chk(tag, dut_vec(), {dn, 8'(bus), 2'(lsb), yv, 8'(y), cv, 8'(c), ccr});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 in reset", dut_vec(), 30'h0);
    rst_n = 1;
    step("R1 after reset");

    // byte-serial input with gaps; mid-field request must be ignored
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < 10; i++) begin
        in_act = 1; xin_a = 8'(b*40 + i*7 + 3); xin_b = 8'(i);
        if (b == 1) dir_req = 1;
        step(b == 1 ? "R2 deferred request" : "R11 byte input");
      end
      in_act = 0;
      step("R13 idle input");
      step("R13 idle input");
    end
    // split 16-bit input
    wide_in = 1;
    for (int i = 0; i < 24; i++) begin
      in_act = (i % 9 != 8); xin_a = 8'(i*11); xin_b = 8'(255 - i*5);
      step("R12 wide input");
    end
    wide_in = 0;

    // switch to output at field start while input keeps toggling
    dir_req = 1; fld_start = 1;
    dec_act = 1; dec_cb = 10'h100; dec_y = 10'h200; dec_cr = 10'h300;
    out_10b = 1;
    step("R2 switch to output");
    for (int i = 0; i < 12; i++) begin
      xin_a = 8'(i); in_act = 1;
      if (i == 5) dec_act = 0;
      if (i == 7) dec_act = 1;
      step("R3 R4 order and no capture");
    end
    in_act = 0;

    // 10-bit sweep
    for (int k = 0; k < 1024; k++) begin
      dec_act = (k % 64 != 63);
      dec_cb = 10'(k); dec_y = ~10'(k); dec_cr = 10'(k) ^ 10'h155;
      step("R5 ten-bit output");
    end
    // dithered 8-bit sweep
    out_10b = 0;
    for (int k = 0; k < 1024; k++) begin
      dec_act = 1;
      dec_cb = 10'(k); dec_y = 10'(1023 - k); dec_cr = 10'(k*3);
      step("R6 dithered output");
    end
    for (int k = 0; k < 256; k++) begin
      dec_act = (k % 3 != 0);
      dec_cb = 10'h3FF; dec_y = 10'(k*4 + 1); dec_cr = 10'h3FE;
      step("R7 lfsr stepping");
    end

    // timing codes with clamping, both widths
    code_en = 1;
    for (int w = 0; w < 2; w++) begin
      out_10b = w[0];
      for (int c = 0; c < 8; c++) begin
        dec_act = 0; dec_cb = 10'h000; dec_y = 10'h3FF; dec_cr = 10'h000;
        code_start = 1; code_f = c[2]; code_v = c[1]; code_h = c[0];
        step("R8 code byte FF");
        step("R8 code byte 00");
        step("R8 code byte 00");
        step("R8 code byte XY");
        for (int i = 0; i < 8; i++) begin
          dec_act = 1;
          dec_cb = (i % 2) ? 10'h3FF : 10'h001;
          dec_y  = (i % 3) ? 10'h000 : 10'h3FD;
          dec_cr = 10'(i * 130);
          step("R10 clamped samples");
        end
      end
    end
    // restart while busy
    code_start = 1; code_f = 1; code_v = 0; code_h = 1;
    step("R8 restart");
    step("R8 restart");
    code_start = 1; code_f = 0; code_v = 1; code_h = 0;
    for (int i = 0; i < 6; i++) step("R8 restart");

    // code_en low: strobes ignored
    code_en = 0;
    for (int i = 0; i < 16; i++) begin
      code_start = (i % 4 == 0); dec_act = 1;
      dec_cb = 10'(i * 60); dec_y = 10'(1023 - i*50); dec_cr = 10'h000;
      step("R9 codes disabled");
    end

    // coincidence: field boundary during a code, then at a code start
    code_en = 1;
    code_start = 1; code_f = 1; code_v = 1; code_h = 0;
    step("R2 code then boundary");
    step("R2 code then boundary");
    dir_req = 0; fld_start = 1; in_act = 1; xin_a = 8'h5A;
    step("R2 boundary mid code");
    for (int i = 0; i < 4; i++) begin xin_a = 8'(i + 1); step("R2 after boundary"); end
    in_act = 0;
    dir_req = 1; fld_start = 1; code_start = 1; code_f = 0; code_v = 0; code_h = 1;
    for (int i = 0; i < 6; i++) step("R2 boundary with code start");
    // mid-field request away from output is deferred
    dir_req = 0;
    for (int i = 0; i < 6; i++) begin in_act = 1; xin_a = 8'(i); step("R2 deferred in output"); end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule